// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. It watches three control inputs (an active-high enable, an active-low select and a read/convert line that is low for convert). It opens a conversion at the moment all three are at their active levels, counting from whichever of them arrived last. A length-select input is captured at that moment and picks either a full 12-bit conversion or a shortened 8-bit one.

During a conversion the block drives a 12-bit trial word to an external DAC and reads back a single comparator bit. It tests one bit per clock, from the most significant bit downward, and holds a busy flag high for the whole run. When the last bit has been decided, the finished word goes into a result register that a separate read interface uses. Repeated start edges during a run cannot restart it, but they do capture the length select again.

Top module: `sar_seq_core`

## Requirements
- R1: A start event is the clock edge at which enable is high, select is low and read/convert is low while at least one of the three was inactive at the previous edge. busy_o and the first trial word appear after that edge. With only two of the three active, nothing starts.
- R2: short_i is captured only at a start event: 1 selects 8 bits and 0 selects 12 bits. Changing it without a start event has no effect.
- R3: busy_o is high for exactly 12 clock cycles in 12-bit mode and exactly 8 in 8-bit mode, and is low otherwise.
- R4: With cmp_i = 1 meaning "input is at least the trial word", a 12-bit conversion ends with result_o equal to the input code.
- R5: An 8-bit conversion ends with result_o[11:4] equal to the input code's upper 8 bits and result_o[3:0] = 4'b1000.
- R6: A start event while busy_o is high neither aborts nor restarts the run. Its length and result are unchanged.
- R7: A start event while busy_o is high captures short_i again. Setting it to 1 early in a 12-bit run ends that run after 8 busy cycles with the 8-bit format.
- R8: result_o holds its previous value throughout a run. It takes the new word at the edge where busy_o falls.
- R9: Reset makes busy_o, trial_o and result_o zero and arms start detection. Inputs held active through reset start a run at the first edge after release.
- R10: Holding all three inputs active after a run ends does not start another run.
- R11: In the first busy cycle trial_o is 12'h800, with only the most significant bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Enable, active high |
| sel_n_i | input | 1 | Select, active low |
| rdconv_i | input | 1 | Read/convert, low requests a conversion |
| short_i | input | 1 | Length select, 1 = 8-bit, 0 = 12-bit |
| cmp_i | input | 1 | Comparator, 1 when the input is at least trial_o |
| trial_o | output | 12 | Trial word to the DAC |
| busy_o | output | 1 | High while a conversion runs |
| result_o | output | 12 | Last completed conversion word |

## Verification
Busy and the 12'h800 trial word are due one edge after the clock edge that first sees all three inputs active. The result and the fall of busy are due together, 12 or 8 edges later. The bench drives every input on the falling clock edge and samples at the next falling edge, so each check reads a value that settled one full rising edge earlier. Busy cycles are counted one falling edge at a time; at each of those samples the held result is compared, and the final word is compared at the first sample where busy is low. Mid-run start edges are placed at known busy-cycle counts, so the expected shortened length can be worked out in advance.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } sar_phase_e;

endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sel_n_i,
  input  logic rdconv_i,
  input  logic short_i,
  output logic start_o,
  output logic short_q_o
);

  logic go;
  logic go_q;
  logic short_q;
  logic short_d;

  // qualifying level: the last input to become active completes it
  assign go      = en_i & ~sel_n_i & ~rdconv_i;
  assign start_o = go & ~go_q;
  assign short_d = start_o ? short_i : short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      short_q <= 1'b0;
    end else begin
      go_q    <= go;
      short_q <= short_d;
    end
  end

  assign short_q_o = short_q;

endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine
  import sar_seq_pkg::*;
#(
  parameter int unsigned WIDTH      = 12,
  parameter int unsigned SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] word_o
);

  localparam int unsigned IDX_W = $clog2(WIDTH);
  localparam int unsigned TAIL  = WIDTH - SHORT_BITS;
  localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(WIDTH - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(TAIL);
  localparam logic [WIDTH-1:0] MSB_ONEHOT = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH-1:0] KEEP_MASK  = ~((WIDTH'(1) << TAIL) - WIDTH'(1));
  localparam logic [WIDTH-1:0] TAIL_PAT   = WIDTH'(1) << (TAIL - 1);

  sar_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WIDTH-1:0] trial_q, trial_d;
  logic [WIDTH-1:0] decided;
  logic [WIDTH-1:0] final_word;
  logic             last_bit;
  logic             ld_en;

  // decision for the bit under test and end-of-run detection
  always_comb begin
    decided          = trial_q;
    decided[idx_q]   = cmp_i;
    last_bit         = (idx_q == '0) || (short_i && (idx_q <= SHORT_LAST));
    final_word       = short_i ? ((decided & KEEP_MASK) | TAIL_PAT) : decided;
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    trial_d = trial_q;
    ld_en   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_CONV;
          idx_d   = TOP_IDX;
          trial_d = MSB_ONEHOT;
          ld_en   = 1'b1;
        end
      end
      PH_CONV: begin
        ld_en = 1'b1;
        if (last_bit) begin
          phase_d = PH_IDLE;
          trial_d = final_word;
        end else begin
          idx_d          = idx_q - IDX_W'(1);
          trial_d        = decided;
          trial_d[idx_d] = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (ld_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      trial_q <= trial_d;
    end
  end

  assign trial_o = trial_q;
  assign busy_o  = (phase_q == PH_CONV);
  assign done_o  = (phase_q == PH_CONV) && last_bit;
  assign word_o  = final_word;

endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] result_o
);

  logic [WIDTH-1:0] result_q;
  logic [WIDTH-1:0] result_d;

  assign result_d = done_i ? word_i : result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else begin
      result_q <= result_d;
    end
  end

  assign result_o = result_q;

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core #(
  parameter int unsigned WIDTH      = 12,
  parameter int unsigned SHORT_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sel_n_i,
  input  logic             rdconv_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic [WIDTH-1:0] result_o
);

  logic             start;
  logic             short_q;
  logic             done;
  logic [WIDTH-1:0] word;

  sar_start_detect u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .sel_n_i  (sel_n_i),
    .rdconv_i (rdconv_i),
    .short_i  (short_i),
    .start_o  (start),
    .short_q_o(short_q)
  );

  sar_step_engine #(
    .WIDTH     (WIDTH),
    .SHORT_BITS(SHORT_BITS)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .short_i(short_q),
    .cmp_i  (cmp_i),
    .trial_o(trial_o),
    .busy_o (busy_o),
    .done_o (done),
    .word_o (word)
  );

  sar_result_hold #(
    .WIDTH(WIDTH)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (done),
    .word_i  (word),
    .result_o(result_o)
  );

endmodule

// File: rtl/sar_seq_core_chk.sv
module sar_seq_core_chk #(
  parameter int unsigned WIDTH      = 12,
  parameter int unsigned SHORT_BITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             sel_n_i,
  input logic             rdconv_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] trial_o,
  input logic [WIDTH-1:0] result_o
);

  localparam int unsigned CNT_W = $clog2(WIDTH + 1) + 1;
  localparam int unsigned TAIL  = WIDTH - SHORT_BITS;
  localparam logic [WIDTH-1:0] MSB_ONEHOT = WIDTH'(1) << (WIDTH - 1);
  localparam logic [TAIL-1:0]  TAIL_PAT   = TAIL'(1) << (TAIL - 1);

  logic             go;
  logic             go_q;
  logic [CNT_W-1:0] run_cnt;

  assign go = en_i & ~sel_n_i & ~rdconv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      run_cnt <= '0;
    end else begin
      go_q    <= go;
      run_cnt <= busy_o ? run_cnt + CNT_W'(1) : '0;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !go_q && !busy_o) |=> busy_o); // R1

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (trial_o == MSB_ONEHOT)); // R11

  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(WIDTH)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(result_o)); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (trial_o != MSB_ONEHOT)); // R6

  AST_SHORT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && run_cnt == CNT_W'(SHORT_BITS)) |-> (result_o[TAIL-1:0] == TAIL_PAT)); // R5

endmodule

bind sar_seq_core sar_seq_core_chk #(
  .WIDTH     (WIDTH),
  .SHORT_BITS(SHORT_BITS)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .sel_n_i (sel_n_i),
  .rdconv_i(rdconv_i),
  .busy_o  (busy_o),
  .trial_o (trial_o),
  .result_o(result_o)
);

// File: tb/test_sar_seq_core.sv
module test_sar_seq_core;

  localparam int NV = 8;
  // bit 12 = short select, bits 11:0 = input code
  localparam logic [12:0] VEC [NV] = '{
    13'h0A5C, 13'h0000, 13'h0FFF, 13'h17F3,
    13'h1000, 13'h1FFF, 13'h0800, 13'h1001
  };

  logic        clk;
  logic        rst_n;
  logic        en_i, sel_n_i, rdconv_i, short_i;
  logic        cmp_i;
  logic [11:0] trial_o, result_o;
  logic        busy_o;
  logic [11:0] code_q;

  int total;
  int bad;
  bit finished;

  sar_seq_core i_sar_seq_core (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_n_i(sel_n_i),
    .rdconv_i(rdconv_i), .short_i(short_i), .cmp_i(cmp_i),
    .trial_o(trial_o), .busy_o(busy_o), .result_o(result_o)
  );

  // comparator model: input at least the trial word
  assign cmp_i = (code_q >= trial_o);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    en_i = 1'b0; sel_n_i = 1'b1; rdconv_i = 1'b1;
  endtask

  function automatic logic [11:0] expect_word(input logic sh, input logic [11:0] c);
    return sh ? {c[11:4], 4'b1000} : c;
  endfunction

  // last: 0 enable, 1 select, 2 read/convert arrives last
  task automatic start_conv(input int last, input logic sh);
    @(negedge clk);
    short_i = sh;
    if (last != 0) en_i = 1'b1;
    if (last != 1) sel_n_i = 1'b0;
    if (last != 2) rdconv_i = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b0, "R1 two of three", busy_o, 0);
    if (last == 0) en_i = 1'b1;
    if (last == 1) sel_n_i = 1'b0;
    if (last == 2) rdconv_i = 1'b0;
    @(negedge clk);
    check(busy_o == 1'b1, "R1 start", busy_o, 1);
    check(trial_o == 12'h800, "R11 first trial", trial_o, 12'h800);
    short_i = ~sh; // R2: no start edge, must not matter
  endtask

  task automatic count_rest(input int n0, input logic [11:0] prev, output int n);
    n = n0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!busy_o) break;
      n++;
      check(result_o == prev, "R8 hold", result_o, prev);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev;
    logic [11:0] expw;
    int n;
    total = 0; bad = 0; finished = 0;
    go_idle(); short_i = 1'b0; code_q = 12'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R9 busy", busy_o, 0);
    check(trial_o == 12'h0, "R9 trial", trial_o, 0);
    check(result_o == 12'h0, "R9 result", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R9 idle after release", busy_o, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      code_q = VEC[i][11:0];
      expw   = expect_word(VEC[i][12], VEC[i][11:0]);
      prev   = result_o;
      start_conv(i % 3, VEC[i][12]);
      count_rest(1, prev, n);
      check(n == (VEC[i][12] ? 8 : 12), "R3 length", n, VEC[i][12] ? 8 : 12);
      check(result_o == expw, VEC[i][12] ? "R5 short word" : "R4 full word", result_o, expw);
      check(busy_o == 1'b0, "R3 busy low", busy_o, 0);
      repeat (3) @(negedge clk);
      check(busy_o == 1'b0, "R10 level hold", busy_o, 0);
      go_idle();
      @(negedge clk);
    end

    // R6: start edge mid-run, length select unchanged
    code_q = 12'h3C9; prev = result_o;
    start_conv(2, 1'b0);
    short_i = 1'b0;
    @(negedge clk);
    @(negedge clk); rdconv_i = 1'b1;
    @(negedge clk); rdconv_i = 1'b0;
    count_rest(4, prev, n);
    check(n == 12, "R6 length", n, 12);
    check(result_o == 12'h3C9, "R6 word", result_o, 12'h3C9);
    go_idle(); @(negedge clk);

    // R7: start edge mid-run captures short select
    code_q = 12'h9B7; prev = result_o;
    start_conv(2, 1'b0);
    short_i = 1'b0;
    @(negedge clk); short_i = 1'b1; rdconv_i = 1'b1;
    @(negedge clk); rdconv_i = 1'b0;
    count_rest(3, prev, n);
    check(n == 8, "R7 length", n, 8);
    check(result_o == 12'h9B8, "R7 word", result_o, 12'h9B8);
    go_idle(); @(negedge clk);

    // R9: inputs held active through reset start a run after release
    code_q = 12'h5A5; short_i = 1'b0;
    rst_n = 1'b0;
    en_i = 1'b1; sel_n_i = 1'b0; rdconv_i = 1'b0;
    repeat (2) @(negedge clk);
    check(result_o == 12'h0, "R9 result cleared", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b1, "R9 armed start", busy_o, 1);
    count_rest(1, 12'h0, n);
    check(n == 12, "R9 length", n, 12);
    check(result_o == 12'h5A5, "R9 word", result_o, 12'h5A5);
    go_idle(); @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule